// File: doc/BRIEF.md
# MDIO Management Master

This block is the master side of a two-wire station management bus. It produces the management clock from the system clock with an even divider. It drives the bidirectional data line through a separate output value and an output-enable, so the tristate pad stays outside the block. A host starts a read or a write of a 16-bit register in an attached PHY with a one-cycle strobe. It then waits for a one-cycle completion pulse, which comes with the read value and an error flag.

The block serves two addressing styles. The short style carries a 5-bit register number in a single frame. The extended style carries a 21-bit address: the upper five bits select a device inside the PHY and the lower sixteen select a register. An extended request is split by the block into two frames. The first is an address frame that loads the register number. The second is the read or write frame itself, sent to the same PHY and device.

On a read the block releases the line once the register field is sent and checks the turnaround bit driven by the PHY. If the PHY does not pull that bit low, the block clocks 32 flush cycles, drops whatever came in and reports all ones with the error flag set.

Top module: `mdio_master`

## Requirements
- R1: Every frame starts with 32 one bits. Then come a 2-bit start code (01 short style, 00 extended style), a 2-bit opcode, the 5-bit PHY address and a 5-bit register/device field, all sent most significant bit first. Short-style opcodes are write 01 and read 10.
- R2: In write and address frames, the 5-bit field is followed by the master driving turnaround bits 1 then 0 and then the 16-bit payload, MSB first. The master then releases the line for one idle clock, so the frame is 65 clocks long.
- R3: In a read frame the output-enable drops after the 5-bit field (bit 46 onward). The line is sampled at bit 47, which is the second turnaround bit. Bits 48..63 are taken as the data, MSB first, and bit 64 is one released idle clock, so the frame is 65 clocks long.
- R4: If the sampled turnaround bit is 1, the master runs 32 more released clocks, so the frame is 80 clocks long. It returns 16'hFFFF with rdErr high, and whatever the PHY sent is discarded.
- R5: An extended request (isC45=1) first sends an address frame. That frame uses start 00, opcode 00, the device number regAddr[20:16] in the 5-bit field and regAddr[15:0] as payload. Right after it comes the data frame with opcode 01 (write) or 11 (read), the same PHY address and the same device number.
- R6: mdioOut and mdioOe change only on a falling edge of mdc while a transfer runs. The bit offered at a rising edge is the one the PHY samples.
- R7: mdc stays high for MDC_DIV/2 and low for MDC_DIV/2 system clocks while running, and it rests low when idle.
- R8: busy is high from the cycle after an accepted start until completion. A start strobe seen while busy is high is ignored and leaves the running transfer unchanged.
- R9: done is high for exactly one cycle after the final clock of the last frame, and busy is low in that same cycle. A start in the done cycle is accepted.
- R10: After reset, busy, done, mdc, mdioOe and rdErr are 0 and rdData is 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| isC45 | input | 1 | 1 selects the extended (address plus data frame) style |
| opWrite | input | 1 | 1 write, 0 read |
| phyAddr | input | 5 | Target PHY address |
| regAddr | input | 21 | Short style: [4:0] register; extended: [20:16] device, [15:0] register |
| wrData | input | 16 | Value to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Last read result |
| rdErr | output | 1 | Last read saw a missing turnaround |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data value toward the pad |
| mdioOe | output | 1 | Pad output-enable |
| mdioIn | input | 1 | Data value from the pad |

## Verification
Two functions can share a single cycle. One is the completion pulse of a transfer that is ending; the other is the acceptance of a fresh request. The bench raises start in exactly the cycle that done is seen high. Acceptance is judged by busy being high one cycle later, and the following transfer is then compared bit by bit against its expected frames. As a contrast, a strobe sent in the middle of a read must change neither the clock count nor the frame contents.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [1:0] {FR_ADDR, FR_WRITE, FR_READ} frameKind_t;

  typedef struct packed {
    logic        run;      // divider enabled
    logic        load;     // load a new serial frame
    logic [63:0] frame;    // frame image, first bit at MSB
    logic        shift;    // advance the serial frame
    logic        capture;  // shift mdioIn into the read register
  } dpCtl_t;

  function automatic logic [63:0] packFrame(input logic [1:0] st, input logic [1:0] op,
                                            input logic [4:0] phy, input logic [4:0] fld,
                                            input logic [15:0] payload);
    return {32'hFFFF_FFFF, st, op, phy, fld, 2'b10, payload};
  endfunction

  function automatic logic [1:0] opCode(input logic c45, input frameKind_t kind);
    logic [1:0] code;
    case (kind)
      FR_ADDR:  code = 2'b00;
      FR_WRITE: code = 2'b01;
      default:  code = c45 ? 2'b11 : 2'b10;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dpCtl_t       ctl,
  input  logic         mdioIn,
  output logic         mdc,
  output logic         mdioOut,
  output logic         riseTick,
  output logic         fallTick,
  output logic [15:0]  rxData
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] divCnt;
  logic [63:0]   txShift;
  logic          tick;

  assign tick     = ctl.run && (divCnt == LAST);
  assign riseTick = tick && !mdc;
  assign fallTick = tick && mdc;
  assign mdioOut  = txShift[63];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divCnt  <= '0;
      mdc     <= 1'b0;
      txShift <= '0;
      rxData  <= '0;
    end else begin
      if (!ctl.run) begin
        divCnt <= '0;
        mdc    <= 1'b0;
      end else if (divCnt == LAST) begin
        divCnt <= '0;
        mdc    <= ~mdc;
      end else begin
        divCnt <= divCnt + 1'b1;
      end

      if (ctl.load)       txShift <= ctl.frame;
      else if (ctl.shift) txShift <= {txShift[62:0], 1'b1};

      if (ctl.capture) rxData <= {rxData[14:0], mdioIn};
    end
  end
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         isC45,
  input  logic         opWrite,
  input  logic [4:0]   phyAddr,
  input  logic [20:0]  regAddr,
  input  logic [15:0]  wrData,
  input  logic         riseTick,
  input  logic         fallTick,
  input  logic         mdioIn,
  input  logic [15:0]  rxData,
  output dpCtl_t       ctl,
  output logic         busy,
  output logic         done,
  output logic [15:0]  rdData,
  output logic         rdErr,
  output logic         mdioOe
);
  localparam logic [6:0] IDX_RELEASE = 7'd45;  // last driven bit of a read frame
  localparam logic [6:0] IDX_TA      = 7'd47;
  localparam logic [6:0] IDX_D_FIRST = 7'd48;
  localparam logic [6:0] IDX_D_LAST  = 7'd63;
  localparam logic [6:0] IDX_END     = 7'd64;
  localparam logic [6:0] IDX_FLUSH   = 7'd79;

  frameKind_t  kind;
  logic        c45Req, wrReq, taBad;
  logic [4:0]  phyReq;
  logic [20:0] regReq;
  logic [15:0] dataReq;
  logic [6:0]  bitIdx, lastIdx;
  logic        accept, frameEnd, chain, finish;
  frameKind_t  startKind, chainKind;
  logic [63:0] startFrame, chainFrame;

  assign accept   = start && !busy;
  assign lastIdx  = taBad ? IDX_FLUSH : IDX_END;
  assign frameEnd = busy && fallTick && (bitIdx == lastIdx);
  assign chain    = frameEnd && (kind == FR_ADDR);
  assign finish   = frameEnd && (kind != FR_ADDR);

  always_comb begin
    startKind = isC45 ? FR_ADDR : (opWrite ? FR_WRITE : FR_READ);
    chainKind = wrReq ? FR_WRITE : FR_READ;
    startFrame = packFrame(isC45 ? 2'b00 : 2'b01, opCode(isC45, startKind), phyAddr,
                           isC45 ? regAddr[20:16] : regAddr[4:0],
                           isC45 ? regAddr[15:0] : (opWrite ? wrData : 16'hFFFF));
    chainFrame = packFrame(2'b00, opCode(1'b1, chainKind), phyReq, regReq[20:16],
                           wrReq ? dataReq : 16'hFFFF);
    ctl.run     = busy;
    ctl.load    = accept || chain;
    ctl.frame   = accept ? startFrame : chainFrame;
    ctl.shift   = busy && fallTick;
    ctl.capture = busy && riseTick && (kind == FR_READ) && !taBad &&
                  (bitIdx >= IDX_D_FIRST) && (bitIdx <= IDX_D_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      rdData  <= '0;
      rdErr   <= 1'b0;
      mdioOe  <= 1'b0;
      kind    <= FR_WRITE;
      c45Req  <= 1'b0;
      wrReq   <= 1'b0;
      phyReq  <= '0;
      regReq  <= '0;
      dataReq <= '0;
      bitIdx  <= '0;
      taBad   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        kind    <= startKind;
        c45Req  <= isC45;
        wrReq   <= opWrite;
        phyReq  <= phyAddr;
        regReq  <= regAddr;
        dataReq <= wrData;
        bitIdx  <= '0;
        taBad   <= 1'b0;
        mdioOe  <= 1'b1;
      end else if (chain) begin
        kind   <= chainKind;
        bitIdx <= '0;
        taBad  <= 1'b0;
        mdioOe <= 1'b1;
      end else if (finish) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        mdioOe <= 1'b0;
        if (kind == FR_READ) begin
          rdErr  <= taBad;
          rdData <= taBad ? 16'hFFFF : rxData;
        end else begin
          rdErr  <= 1'b0;
        end
      end else if (busy) begin
        if (riseTick && (kind == FR_READ) && (bitIdx == IDX_TA) && mdioIn)
          taBad <= 1'b1;
        if (fallTick) begin
          bitIdx <= bitIdx + 1'b1;
          if ((kind == FR_READ) && (bitIdx == IDX_RELEASE)) mdioOe <= 1'b0;
          if ((kind != FR_READ) && (bitIdx == IDX_D_LAST))  mdioOe <= 1'b0;
        end
      end
    end
  end

  logic unusedC45;
  assign unusedC45 = c45Req;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int MDC_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        isC45,
  input  logic        opWrite,
  input  logic [4:0]  phyAddr,
  input  logic [20:0] regAddr,
  input  logic [15:0] wrData,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdData,
  output logic        rdErr,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  localparam int HALF = MDC_DIV / 2;

  dpCtl_t      ctl;
  logic        riseTick, fallTick;
  logic [15:0] rxData;

  mdio_dp #(.HALF(HALF)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .mdioIn(mdioIn), .mdc(mdc),
    .mdioOut(mdioOut), .riseTick(riseTick), .fallTick(fallTick), .rxData(rxData)
  );

  mdio_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .isC45(isC45), .opWrite(opWrite),
    .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData), .riseTick(riseTick),
    .fallTick(fallTick), .mdioIn(mdioIn), .rxData(rxData), .ctl(ctl), .busy(busy),
    .done(done), .rdData(rdData), .rdErr(rdErr), .mdioOe(mdioOe)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int MDC_DIV = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe,
  input logic        rdErr,
  input logic [15:0] rdData
);
  localparam int HALF = MDC_DIV / 2;
  localparam int HW = $clog2(HALF + 2) + 1;

  logic [HW-1:0] highCnt;
  always_ff @(posedge clk) begin
    if (!rst_n)   highCnt <= '0;
    else if (mdc) highCnt <= highCnt + 1'b1;
    else          highCnt <= '0;
  end

  p_out_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mdioOut != $past(mdioOut))) |-> $fell(mdc));

  p_oe_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mdioOe != $past(mdioOe))) |-> $fell(mdc));

  p_mdc_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> (highCnt == HW'(HALF)));

  p_mdc_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !mdc);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_err_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdErr |-> (rdData == 16'hFFFF));
endmodule

bind mdio_master mdio_master_chk #(.MDC_DIV(MDC_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mdc(mdc),
  .mdioOut(mdioOut), .mdioOe(mdioOe), .rdErr(rdErr), .rdData(rdData)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int DIV = 4;
  localparam int HALF = DIV / 2;
  localparam int NV = 6;
  // {c45, write, taBad, phy[4:0], reg[20:0], data[15:0]}
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 5'h01, 21'h00004, 16'hA5C3},
    {1'b0, 1'b0, 1'b0, 5'h1F, 21'h00002, 16'h1234},
    {1'b0, 1'b0, 1'b1, 5'h03, 21'h00001, 16'hBEEF},
    {1'b1, 1'b1, 1'b0, 5'h0A, {5'h07, 16'h8001}, 16'h0F0F},
    {1'b1, 1'b0, 1'b0, 5'h11, {5'h1E, 16'hFFFE}, 16'h8001},
    {1'b1, 1'b0, 1'b1, 5'h00, {5'h01, 16'h0000}, 16'h5555}
  };

  logic clk = 0, rst_n = 0, start = 0, isC45 = 0, opWrite = 0, mdioIn = 1;
  logic [4:0] phyAddr = 0;
  logic [20:0] regAddr = 0;
  logic [15:0] wrData = 0;
  logic busy, done, rdErr, mdc, mdioOut, mdioOe;
  logic [15:0] rdData;

  mdio_master #(.MDC_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .isC45(isC45), .opWrite(opWrite),
    .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData), .busy(busy), .done(done),
    .rdData(rdData), .rdErr(rdErr), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioIn)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0, riseCnt = 0, tRise = 0, badPeriod = 0, r6Bad = 0;
  logic logOe [256], logOut [256], expOe [256], expOut [256], resp [256];
  int expTotal;
  logic prevBusy = 0, prevOut = 0, prevOe = 0, prevMdc = 0;

  always @(posedge clk) cyc++;
  always @(posedge mdc) begin
    if (riseCnt < 256) begin logOe[riseCnt] = mdioOe; logOut[riseCnt] = mdioOut; end
    riseCnt++;
    tRise = cyc;
  end
  always @(negedge mdc) begin
    if (cyc - tRise != HALF) badPeriod++;
    mdioIn = (riseCnt < 256) ? resp[riseCnt] : 1'b1;
  end
  always @(negedge clk) begin
    if (busy && prevBusy && (mdioOut != prevOut || mdioOe != prevOe) && !(prevMdc && !mdc))
      r6Bad++;
    prevBusy = busy; prevOut = mdioOut; prevOe = mdioOe; prevMdc = mdc;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected frame image: header bits then either driven payload or released tail.
  task automatic addFrame(input int off, input logic [1:0] st, input logic [1:0] op,
                          input logic [4:0] phy, input logic [4:0] fld, input bit rd,
                          input bit bad, input logic [15:0] val, output int len);
    logic [13:0] hdr;
    hdr = {st, op, phy, fld};
    for (int i = 0; i < 32; i++) begin expOe[off+i] = 1; expOut[off+i] = 1; end
    for (int i = 0; i < 14; i++) begin expOe[off+32+i] = 1; expOut[off+32+i] = hdr[13-i]; end
    len = (rd && bad) ? 80 : 65;
    for (int i = 46; i < len; i++) begin expOe[off+i] = 0; expOut[off+i] = 1; end
    if (!rd) begin
      expOut[off+46] = 1; expOut[off+47] = 0; expOe[off+46] = 1; expOe[off+47] = 1;
      for (int i = 0; i < 16; i++) begin expOe[off+48+i] = 1; expOut[off+48+i] = val[15-i]; end
    end else begin
      resp[off+47] = bad;
      for (int i = 0; i < 16; i++) resp[off+48+i] = val[15-i];
    end
  endtask

  task automatic prepare(input logic [44:0] v);
    int len1, len2;
    for (int i = 0; i < 256; i++) begin resp[i] = 1; expOe[i] = 0; expOut[i] = 1; end
    if (!v[44]) begin
      addFrame(0, 2'b01, v[43] ? 2'b01 : 2'b10, v[41:37], v[20:16], !v[43], v[42], v[15:0], len1);
      expTotal = len1;
    end else begin
      addFrame(0, 2'b00, 2'b00, v[41:37], v[36:32], 0, 0, v[31:16], len1);
      addFrame(65, 2'b00, v[43] ? 2'b01 : 2'b11, v[41:37], v[36:32], !v[43], v[42], v[15:0], len2);
      expTotal = len1 + len2;
    end
  endtask

  task automatic launch(input logic [44:0] v);
    prepare(v);
    isC45 = v[44]; opWrite = v[43]; phyAddr = v[41:37]; regAddr = v[36:16]; wrData = v[15:0];
    riseCnt = 0; mdioIn = 1; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 4000) begin @(negedge clk); n++; end
    chk(done, "R9 done seen", done, 1);
  endtask

  task automatic judge(input logic [44:0] v, input string tag);
    int mism = 0;
    chk(riseCnt == expTotal, {tag, " R2/R3/R4/R5 clock count"}, riseCnt, expTotal);
    for (int i = 0; i < expTotal && i < 256; i++)
      if (logOe[i] != expOe[i] || (expOe[i] && logOut[i] != expOut[i])) mism++;
    chk(mism == 0, {tag, " R1/R2/R3/R5 frame bits"}, mism, 0);
    if (!v[43]) begin
      chk(rdErr == v[42], {tag, " R4 error flag"}, rdErr, v[42]);
      chk(rdData == (v[42] ? 16'hFFFF : v[15:0]), {tag, " R3/R4 read data"}, rdData,
          v[42] ? 16'hFFFF : v[15:0]);
    end else chk(rdErr == 0, {tag, " R2 no error on write"}, rdErr, 0);
    chk(!busy, {tag, " R9 busy low with done"}, busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !mdc && !mdioOe, "R10 reset controls", {busy, done, mdc, mdioOe}, 0);
    chk(!rdErr && rdData == 0, "R10 reset result", rdData, 0);

    for (int k = 0; k < NV; k++) begin
      launch(VEC[k]);
      chk(busy, "R8 busy after start", busy, 1);
      waitDone();
      judge(VEC[k], $sformatf("vec%0d", k));
      @(negedge clk);
      chk(!done, "R9 done one cycle", done, 0);
      chk(!mdc, "R7 mdc rests low", mdc, 0);
    end

    // R8: a strobe in the middle of a read is ignored
    launch(VEC[1]);
    repeat (100) @(negedge clk);
    isC45 = 1; opWrite = 1; phyAddr = 5'h15; start = 1;
    @(negedge clk); start = 0;
    waitDone();
    judge(VEC[1], "R8 ignored start");
    @(negedge clk);
    chk(!busy, "R8 no extra transfer", busy, 0);

    // R9: start in the done cycle is accepted
    launch(VEC[0]);
    waitDone();
    judge(VEC[0], "R9 first");
    launch(VEC[3]);
    chk(busy, "R9 start on done accepted", busy, 1);
    waitDone();
    judge(VEC[3], "R9 second");
    @(negedge clk);

    chk(badPeriod == 0, "R7 mdc high time", badPeriod, 0);
    chk(r6Bad == 0, "R6 data changes only on mdc fall", r6Bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule